// File: doc/BRIEF.md
# Vertically Scheduled 7-Point Stencil Engine

This block sums each interior voxel of an 8x8x8 volume with its six face neighbours (one step along x, y and z in both directions) and writes the result to an output port. The input volume is stored inside the block across 7 single-port banks. Each voxel goes to the bank selected by its linear address modulo 7. While the block is idle, the volume is filled through a load port.

The block handles the 6 interior i-iterations of one (j,k) row as a group of 7 lanes. In each read cycle it fetches one of the seven neighbour references for all 7 lanes at once. Seven consecutive addresses always fall in 7 different banks, so every bank is used exactly once in that cycle. The first six references are held in a register buffer of 6x7 values. When the seventh reference arrives, all seven lane sums are formed together. The sums are then written out one per cycle. While this happens, the next group's centre values are already being read. The seventh lane of each group lies outside the interior and is dropped.

A one-cycle start pulse launches a run over all 36 rows. A one-cycle done pulse marks the end of the run.

Top module: `stencil7_vsched`

## Requirements
- R1: After reset, out_valid_o and done_o are low and the block is idle until a start pulse.
- R2: A load of data D at linear address a = i + 8j + 64k (while idle) stores D in bank a mod 7 at row a div 7, so that it is the value the stencil later sees at voxel (i,j,k).
- R3: For every voxel with i, j and k each in 1..6, the block writes out_addr_o = a and out_data_o = v[a] + v[a+1] + v[a-1] + v[a+8] + v[a-8] + v[a+64] + v[a-64].
- R4: Outputs appear in increasing address order: i fastest, then j, then k, for 216 writes per run.
- R5: Each read cycle fetches one reference for 7 consecutive lanes from all 7 banks at once. References for one row are read in the fixed order 0, +1, -1, +8, -8, +64, -64 over 7 consecutive cycles, and one row is started every 7 cycles.
- R6: The first write occurs 9 clock edges after the edge that samples start_i. After that, each row gives 6 writes on consecutive cycles followed by one cycle with no write.
- R7: No voxel with i, j or k equal to 0 or 7 is ever written. The seventh lane of each row is masked.
- R8: done_o is high for exactly one cycle, one cycle after the last write (voxel 6,6,6), which is 260 edges after the start edge.
- R9: A start pulse while a run is in progress is ignored. The run's output sequence and timing are unchanged.
- R10: Sums are DW+3 bits wide and never wrap. With every input at its maximum value, each output equals 7 times that maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that launches a run |
| load_en_i | input | 1 | Volume write enable (idle only) |
| load_addr_i | input | 9 | Linear voxel address i + 8j + 64k |
| load_data_i | input | 8 | Voxel value |
| out_valid_o | output | 1 | Output write strobe |
| out_addr_o | output | 9 | Linear address of the written voxel |
| out_data_o | output | 11 | Seven-term neighbourhood sum |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with its defaults: element width 8, edge 8 and 7 banks. With these values a full run of 216 outputs, including the masked seventh lane and both volume faces, takes only about 260 cycles. The bench runs three volumes: random values, all-maximum values that reach the 11-bit sum ceiling, and an address-derived pattern. A mis-ordered or mis-offset neighbour read changes a sum, so it shows up in the data. One run injects a second start mid-flight and expects the cycle-exact timeline to stay the same.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int unsigned NREF = 7;

  // neighbour order: centre, +x, -x, +y, -y, +z, -z
  function automatic int ref_offset(input int unsigned r, input int unsigned dim);
    case (r)
      0: return 0;
      1: return 1;
      2: return -1;
      3: return int'(dim);
      4: return -int'(dim);
      5: return int'(dim * dim);
      default: return -int'(dim * dim);
    endcase
  endfunction
endpackage

// File: rtl/stencil_bank.sv
module stencil_bank #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 74,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    else if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/stencil_seq.sv
module stencil_seq
  import stencil_pkg::*;
#(
  parameter int unsigned DIM = 8,
  parameter int unsigned VAW = 9,
  parameter int unsigned RW  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  output logic           busy_o,
  output logic [RW-1:0]  ref_o,
  output logic [VAW-1:0] cbase_o,
  output logic [VAW-1:0] rbase_o,
  output logic           last_o
);
  localparam int unsigned IW = $clog2(DIM);
  localparam int unsigned HI = DIM - 2;

  logic          busy_q;
  logic [RW-1:0] ref_q;
  logic [IW-1:0] j_q, k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ref_q  <= '0;
      j_q    <= IW'(1);
      k_q    <= IW'(1);
    end else if (!busy_q) begin
      if (start_i) busy_q <= 1'b1;
      ref_q <= '0;
      j_q   <= IW'(1);
      k_q   <= IW'(1);
    end else if (ref_q == RW'(NREF - 1)) begin
      ref_q <= '0;
      if (j_q == IW'(HI)) begin
        j_q <= IW'(1);
        if (k_q == IW'(HI)) busy_q <= 1'b0;
        else k_q <= k_q + IW'(1);
      end else begin
        j_q <= j_q + IW'(1);
      end
    end else begin
      ref_q <= ref_q + RW'(1);
    end
  end

  always_comb begin
    cbase_o = VAW'(1 + DIM * int'(j_q) + DIM * DIM * int'(k_q));
    rbase_o = VAW'(int'(cbase_o) + ref_offset(int'(ref_q), DIM));
  end

  assign busy_o = busy_q;
  assign ref_o  = ref_q;
  assign last_o = busy_q && ref_q == RW'(NREF - 1) && j_q == IW'(HI) && k_q == IW'(HI);

  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (j_q >= IW'(1) && j_q <= IW'(HI) && k_q >= IW'(1) && k_q <= IW'(HI)))
    else $error("row index out of interior");

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && ref_q != RW'(NREF - 1) |=> ref_q == $past(ref_q) + RW'(1))
    else $error("start restarted a running sweep");
endmodule

// File: rtl/stencil_acc.sv
module stencil_acc
  import stencil_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned NB  = 7,
  parameter int unsigned DIM = 8,
  parameter int unsigned VAW = 9,
  parameter int unsigned RW  = 3,
  parameter int unsigned SW  = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rvld_i,
  input  logic [RW-1:0]  rref_i,
  input  logic [VAW-1:0] rbase_i,
  input  logic           rlast_i,
  input  logic [DW-1:0]  lane_i [NB],
  output logic           out_valid_o,
  output logic [VAW-1:0] out_addr_o,
  output logic [SW-1:0]  out_data_o,
  output logic           done_o
);
  localparam int unsigned ACT = DIM - 2;
  localparam int unsigned LW  = $clog2(NB);
  localparam int unsigned NH  = NREF - 1;

  logic [DW-1:0]  hold_q [NH][NB];
  logic [SW-1:0]  sum_d  [NB];
  logic [SW-1:0]  sum_q  [NB];
  logic [VAW-1:0] grp_base_q;
  logic           grp_last_q, emit_q, fin_q;
  logic [LW-1:0]  lane_q;
  logic           fire;

  assign fire = rvld_i && rref_i == RW'(NREF - 1);

  for (genvar r = 0; r < NH; r++) begin : g_hold
    always_ff @(posedge clk_i) begin
      if (rvld_i && rref_i == RW'(r)) begin
        for (int l = 0; l < NB; l++) hold_q[r][l] <= lane_i[l];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < NB; l++) begin
      sum_d[l] = SW'(lane_i[l]);
      for (int r = 0; r < NH; r++) sum_d[l] = sum_d[l] + SW'(hold_q[r][l]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (fire) begin
      for (int l = 0; l < NB; l++) sum_q[l] <= sum_d[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      emit_q      <= 1'b0;
      lane_q      <= '0;
      grp_base_q  <= '0;
      grp_last_q  <= 1'b0;
      out_valid_o <= 1'b0;
      out_addr_o  <= '0;
      out_data_o  <= '0;
      fin_q       <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      out_valid_o <= emit_q;
      if (emit_q) begin
        out_addr_o <= grp_base_q + VAW'(lane_q);
        out_data_o <= sum_q[lane_q];
      end
      fin_q  <= emit_q && lane_q == LW'(ACT - 1) && grp_last_q;
      done_o <= fin_q;
      if (fire) begin
        emit_q     <= 1'b1;
        lane_q     <= '0;
        grp_base_q <= rbase_i;
        grp_last_q <= rlast_i;
      end else if (emit_q && lane_q == LW'(ACT - 1)) begin
        emit_q <= 1'b0;
      end else if (emit_q) begin
        lane_q <= lane_q + LW'(1);
      end
    end
  end

  assert_ref_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvld_i && rref_i != '0 |-> $past(rvld_i) && rref_i == $past(rref_i) + RW'(1))
    else $error("reference arrived out of order");

  assert_interior_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(out_addr_o) % DIM >= 1 && int'(out_addr_o) % DIM <= DIM - 2 &&
                     (int'(out_addr_o) / DIM) % DIM >= 1 && (int'(out_addr_o) / DIM) % DIM <= DIM - 2 &&
                     int'(out_addr_o) / (DIM * DIM) >= 1 && int'(out_addr_o) / (DIM * DIM) <= DIM - 2))
    else $error("boundary voxel written");

  assert_done_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(out_valid_o))
    else $error("done without a preceding write");

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done longer than one cycle");
endmodule

// File: rtl/stencil7_vsched.sv
module stencil7_vsched
  import stencil_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned DIM = 8,
  parameter int unsigned NB  = 7,
  localparam int unsigned VAW = $clog2(DIM * DIM * DIM),
  localparam int unsigned SW  = DW + $clog2(NREF + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           load_en_i,
  input  logic [VAW-1:0] load_addr_i,
  input  logic [DW-1:0]  load_data_i,
  output logic           out_valid_o,
  output logic [VAW-1:0] out_addr_o,
  output logic [SW-1:0]  out_data_o,
  output logic           done_o
);
  localparam int unsigned DEPTH = (DIM * DIM * DIM + NB - 1) / NB;
  localparam int unsigned BAW   = $clog2(DEPTH);
  localparam int unsigned BW    = $clog2(NB);
  localparam int unsigned RW    = $clog2(NREF);

  logic           busy, last;
  logic [RW-1:0]  ref_idx;
  logic [VAW-1:0] cbase, rbase;
  logic [BW-1:0]  rot, ld_bank;
  logic [BAW-1:0] ld_row;
  logic [DW-1:0]  bank_rdata [NB];
  logic [DW-1:0]  lane_data  [NB];

  logic           rvld_q, rlast_q;
  logic [RW-1:0]  rref_q;
  logic [VAW-1:0] rcbase_q;
  logic [BW-1:0]  rrot_q;

  stencil_seq #(.DIM(DIM), .VAW(VAW), .RW(RW)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .busy_o(busy), .ref_o(ref_idx), .cbase_o(cbase), .rbase_o(rbase), .last_o(last)
  );

  assign rot     = BW'(int'(rbase) % NB);
  assign ld_bank = BW'(int'(load_addr_i) % NB);
  assign ld_row  = BAW'(int'(load_addr_i) / NB);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    int             lane_b;
    logic [BAW-1:0] rd_row, addr_b;
    logic           we_b;

    always_comb begin
      lane_b = (b + NB - int'(rot)) % NB;
      rd_row = BAW'((int'(rbase) + lane_b) / NB);
    end
    assign we_b   = load_en_i && !busy && ld_bank == BW'(b);
    assign addr_b = busy ? rd_row : ld_row;

    stencil_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk_i, .we_i(we_b), .re_i(busy), .addr_i(addr_b),
      .wdata_i(load_data_i), .rdata_o(bank_rdata[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvld_q   <= 1'b0;
      rref_q   <= '0;
      rcbase_q <= '0;
      rlast_q  <= 1'b0;
      rrot_q   <= '0;
    end else begin
      rvld_q   <= busy;
      rref_q   <= ref_idx;
      rcbase_q <= cbase;
      rlast_q  <= last;
      rrot_q   <= rot;
    end
  end

  always_comb begin
    for (int l = 0; l < NB; l++) lane_data[l] = bank_rdata[BW'((int'(rrot_q) + l) % NB)];
  end

  stencil_acc #(.DW(DW), .NB(NB), .DIM(DIM), .VAW(VAW), .RW(RW), .SW(SW)) u_acc (
    .clk_i, .rst_ni,
    .rvld_i(rvld_q), .rref_i(rref_q), .rbase_i(rcbase_q), .rlast_i(rlast_q),
    .lane_i(lane_data),
    .out_valid_o, .out_addr_o, .out_data_o, .done_o
  );

  assert_bank_span_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> int'(rbase) + NB - 1 < DIM * DIM * DIM)
    else $error("read group leaves the volume");

  assert_load_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> rvld_q)
    else $error("read data not tagged after issue");
endmodule

// File: tb/test_stencil7_vsched.sv
`timescale 1ns/1ps
module test_stencil7_vsched;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       load_en_i = 1'b0;
  logic [8:0] load_addr_i = '0;
  logic [7:0] load_data_i = '0;
  logic        out_valid_o;
  logic [8:0]  out_addr_o;
  logic [10:0] out_data_o;
  logic        done_o;

  int n_vec = 0;
  int n_bad = 0;
  int vol   [512];
  int exp_a [$];
  int exp_d [$];

  always #2 clk_i = ~clk_i;

  stencil7_vsched i_stencil7_vsched (.*);

  task automatic check(input string tag, input int act, input int expv, input int cyc);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endtask

  task automatic load_volume(input int mode);
    for (int a = 0; a < 512; a++) begin
      case (mode)
        0: vol[a] = int'($urandom_range(0, 255));
        1: vol[a] = 255;
        default: vol[a] = (a * 37 + 11) % 256;
      endcase
      @(negedge clk_i);
      load_en_i   = 1'b1;
      load_addr_i = 9'(a);
      load_data_i = 8'(vol[a]);
    end
    @(negedge clk_i);
    load_en_i = 1'b0;
    exp_a.delete();
    exp_d.delete();
    for (int k = 1; k <= 6; k++)
      for (int j = 1; j <= 6; j++)
        for (int i = 1; i <= 6; i++) begin
          int c;
          c = i + 8 * j + 64 * k;
          exp_a.push_back(c);
          exp_d.push_back(vol[c] + vol[c+1] + vol[c-1] + vol[c+8] + vol[c-8] + vol[c+64] + vol[c-64]);
        end
  endtask

  // cyc counts edges after the one that sampled start
  task automatic run(input string dtag, input int extra_start);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int cyc = 0; cyc <= 270; cyc++) begin
      bit ev;
      int e;
      ev = cyc >= 9 && (cyc - 9) % 7 < 6 && (cyc - 9) / 7 < 36;
      check("R6 R7 R9 write strobe", int'(out_valid_o), int'(ev), cyc);
      if (ev && out_valid_o) begin
        e = ((cyc - 9) / 7) * 6 + (cyc - 9) % 7;
        check("R4 R7 address", int'(out_addr_o), exp_a[e], cyc);
        check(dtag, int'(out_data_o), exp_d[e], cyc);
      end
      check("R8 done", int'(done_o), int'(cyc == 260), cyc);
      if (extra_start != 0 && cyc == extra_start) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset valid", int'(out_valid_o), 0, 0);
    check("R1 reset done", int'(done_o), 0, 0);
    repeat (20) @(negedge clk_i);
    check("R1 idle valid", int'(out_valid_o), 0, 0);

    load_volume(0);
    run("R2 R3 R5 data random", 0);
    load_volume(1);
    run("R10 data saturated", 0);
    load_volume(2);
    run("R3 R9 data restart", 100);
    check("R9 queue size", exp_a.size(), 216, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule